// File: doc/BRIEF.md
# Asynchronous SRAM controller

This block lets a clocked system use one or more external asynchronous static RAMs of 131,072 bytes each. A requester hands it one access at a time over a valid/ready port: an address, a read/write flag and, for writes, one byte of data. The controller then produces the memory strobes from registered outputs. These strobes are a chip-enable pair per device (one active low, one active high), an active-low output enable, an active-low write enable, and the data bus split into output, output-enable and input lanes for the pad ring. Each phase lasts a whole number of clock cycles, and parameters set those counts. The user picks the counts by rounding the memory's nanosecond limits up to the clock period.

Address bits above the 17 word bits choose the bank. Only that bank sees its enable pair asserted, and every other device is held deselected on both enables. A read holds the output enable low for the access window. The byte on the data input is captured on the last cycle of that window and returned with a one-cycle response pulse. A turnaround interval follows every read, so the memory's outputs are off before the controller can drive the bus again. A write holds the output enable high throughout. Because of that, the plain minimum write pulse is enough, and the longer pulse needed when the memory's outputs must first turn off does not apply.

Back-pressure: `req_ready` is high only while the controller is idle. A request transfers on a cycle where `req_valid` and `req_ready` are both high. While it waits, the requester must hold the request fields stable. The response has no ready. The requester must accept `rsp_valid` in the cycle it is high.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_ready is 1, rsp_valid is 0, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, every mem_ce bit is 0 and every mem_ce_n bit is 1.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the cycle after that edge until the access and its trailing interval have ended.
- R3: A read accepted at edge k holds mem_oe_n at 0 and mem_we_n at 1, with the selected bank's enables asserted and mem_addr equal to the request's low 17 bits, for exactly RD_CYC cycles starting right after edge k.
- R4: The byte on mem_dq_i in the last cycle of a read window appears on rsp_rdata, with rsp_valid at 1 for exactly one cycle, the cycle after the window. rsp_valid is 0 at all other times.
- R5: After a read window come TA_CYC cycles in which every bank is deselected, mem_oe_n and mem_we_n are 1 and mem_dq_oe is 0, and req_ready stays 0. req_ready returns to 1 in the cycle after these.
- R6: A write accepted at edge k gives one setup cycle, then WP_CYC cycles with mem_we_n at 0, then one recovery cycle with mem_we_n at 1. Bank enables and mem_addr are asserted and unchanged across all three phases, and mem_oe_n is 1 throughout.
- R7: mem_dq_oe is 1 exactly while mem_we_n is 0. mem_dq_o equals the request's write byte through the pulse and the recovery cycle, so the data changes only after the write enable has risen.
- R8: Address bits [ADDR_W-1:17] select bank b. During an access only mem_ce[b] is 1 and only mem_ce_n[b] is 0. All other banks have mem_ce at 0 and mem_ce_n at 1.
- R9: Outside an access and its trailing interval, all banks are deselected, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs are registered on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (18) | Bank bits above the 17-bit word address |
| req_wdata | input | DATA_W (8) | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W (8) | Captured read byte |
| mem_addr | output | WORD_AW (17) | Word address to the memories |
| mem_ce_n | output | NUM_BANKS (2) | Active-low chip enable per bank |
| mem_ce | output | NUM_BANKS (2) | Active-high chip enable per bank |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | DATA_W (8) | Data toward the bus pads |
| mem_dq_oe | output | 1 | Pad driver enable for mem_dq_o |
| mem_dq_i | input | DATA_W (8) | Data from the bus pads |

## Verification
The assertions assume three things. Reset is asserted before the first clock edge. Every timing parameter is at least one. Request fields stay stable while a request waits for ready, so the address and data captured at the transfer edge are the ones that were offered. The stimulus holds a request constant from the cycle it raises valid until the cycle after the transfer. It drives the data input from a behavioural memory only while the selected bank has its output enable low and its write enable high, and it drives a fixed filler byte at all other times. It also mixes back-to-back requests, requests raised while the controller is busy, and requests after idle gaps, across both banks and both ends of the word range.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_RTURN = 3'd2,
    ST_WSET  = 3'd3,
    ST_WPUL  = 3'd4,
    ST_WREC  = 3'd5
  } asram_st_e;

  function automatic int cnt_bits(input int n);
    if (n < 2) return 1;
    return $clog2(n);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC = 3,
  parameter int WP_CYC = 2,
  parameter int TA_CYC = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      req_write,
  output logic      req_ready,
  output logic      accept,
  output logic      cap_en,
  output asram_st_e state_d
);

  localparam int CNT_W = cnt_bits(max3(RD_CYC, WP_CYC, TA_CYC));
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);

  asram_st_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_zero;

  always_comb begin
    cnt_zero  = (cnt_q == '0);
    req_ready = (state_q == ST_IDLE);
    accept    = req_valid && req_ready;
    cap_en    = (state_q == ST_RD) && cnt_zero;
    state_d   = state_q;
    cnt_d     = cnt_zero ? cnt_q : cnt_q - 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_write) begin
            state_d = ST_WSET;
          end else begin
            state_d = ST_RD;
            cnt_d   = RD_LOAD;
          end
        end
      end
      ST_RD: begin
        if (cnt_zero) begin
          state_d = ST_RTURN;
          cnt_d   = TA_LOAD;
        end
      end
      ST_RTURN: begin
        if (cnt_zero) state_d = ST_IDLE;
      end
      ST_WSET: begin
        state_d = ST_WPUL;
        cnt_d   = WP_LOAD;
      end
      ST_WPUL: begin
        if (cnt_zero) state_d = ST_WREC;
      end
      ST_WREC: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/asram_bank_dec.sv
module asram_bank_dec #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic                 en,
  input  logic [BANK_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] hit
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign hit[b] = en && (bank == BANK_W'(b));
  end

endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int WORD_AW   = 17,
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = WORD_AW + BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  asram_st_e            state_d,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic [WORD_AW-1:0]   mem_addr,
  output logic [NUM_BANKS-1:0] mem_ce_n,
  output logic [NUM_BANKS-1:0] mem_ce,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic [DATA_W-1:0]    mem_dq_o,
  output logic                 mem_dq_oe
);

  logic [BANK_W-1:0]    bank_q;
  logic [BANK_W-1:0]    bank_d;
  logic                 sel_d;
  logic [NUM_BANKS-1:0] hit;

  always_comb begin
    bank_d = accept ? req_addr[ADDR_W-1:WORD_AW] : bank_q;
    sel_d  = (state_d == ST_RD)   || (state_d == ST_WSET) ||
             (state_d == ST_WPUL) || (state_d == ST_WREC);
  end

  asram_bank_dec #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_dec (
    .en   (sel_d),
    .bank (bank_d),
    .hit  (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q    <= '0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_ce    <= '0;
      mem_ce_n  <= '1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      if (accept) begin
        bank_q   <= req_addr[ADDR_W-1:WORD_AW];
        mem_addr <= req_addr[WORD_AW-1:0];
        mem_dq_o <= req_wdata;
      end
      mem_ce    <= hit;
      mem_ce_n  <= ~hit;
      mem_oe_n  <= (state_d != ST_RD);
      mem_we_n  <= (state_d != ST_WPUL);
      mem_dq_oe <= (state_d == ST_WPUL);
    end
  end

endmodule

// File: rtl/asram_rdcap.sv
module asram_rdcap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cap_en;
      if (cap_en) rsp_rdata <= mem_dq_i;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int WORD_AW   = 17,
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 2,
  parameter int RD_CYC    = 3,
  parameter int WP_CYC    = 2,
  parameter int TA_CYC    = 2,
  localparam int ADDR_W   = WORD_AW + $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [WORD_AW-1:0]   mem_addr,
  output logic [NUM_BANKS-1:0] mem_ce_n,
  output logic [NUM_BANKS-1:0] mem_ce,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic [DATA_W-1:0]    mem_dq_o,
  output logic                 mem_dq_oe,
  input  logic [DATA_W-1:0]    mem_dq_i
);

  logic      accept;
  logic      cap_en;
  asram_st_e state_d;

  asram_seq #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .TA_CYC (TA_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .cap_en    (cap_en),
    .state_d   (state_d)
  );

  asram_pins #(
    .WORD_AW   (WORD_AW),
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .state_d   (state_d),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
  );

  asram_rdcap #(
    .DATA_W (DATA_W)
  ) u_rdcap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .mem_dq_i  (mem_dq_i),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int WORD_AW   = 17,
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 2,
  parameter int RD_CYC    = 3,
  parameter int WP_CYC    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ready,
  input logic                 rsp_valid,
  input logic [WORD_AW-1:0]   mem_addr,
  input logic [NUM_BANKS-1:0] mem_ce_n,
  input logic [NUM_BANKS-1:0] mem_ce,
  input logic                 mem_oe_n,
  input logic                 mem_we_n,
  input logic [DATA_W-1:0]    mem_dq_o,
  input logic                 mem_dq_oe
);

  logic [7:0] we_lo_cnt;
  logic [7:0] oe_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      oe_lo_cnt <= '0;
    end else begin
      we_lo_cnt <= mem_we_n ? 8'd0 : ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1);
      oe_lo_cnt <= mem_oe_n ? 8'd0 : ((oe_lo_cnt == 8'hFF) ? oe_lo_cnt : oe_lo_cnt + 8'd1);
    end
  end

  a_r7_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  a_r3_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  a_r8_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_ce));

  a_r8_enable_pair: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n == ~mem_ce);

  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_ce) && (mem_ce != '0)));

  a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mem_we_n) |-> $stable(mem_dq_o));

  a_r6_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt == 8'(WP_CYC)));

  a_r3_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_lo_cnt == 8'(RD_CYC)));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r4_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($rose(mem_oe_n) && !req_ready));

  a_r5_no_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |=> (!mem_dq_oe && !req_ready));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((mem_ce == '0) && mem_oe_n && mem_we_n && !mem_dq_oe));

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .WORD_AW   (WORD_AW),
  .DATA_W    (DATA_W),
  .NUM_BANKS (NUM_BANKS),
  .RD_CYC    (RD_CYC),
  .WP_CYC    (WP_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_ce    (mem_ce),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_o  (mem_dq_o),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int WORD_AW   = 17;
  localparam int DATA_W    = 8;
  localparam int NUM_BANKS = 2;
  localparam int ADDR_W    = 18;
  localparam int RD_CYC    = 3;
  localparam int WP_CYC    = 2;
  localparam int TA_CYC    = 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic                 req_write = 1'b0;
  logic [ADDR_W-1:0]    req_addr = '0;
  logic [DATA_W-1:0]    req_wdata = '0;
  logic                 rsp_valid;
  logic [DATA_W-1:0]    rsp_rdata;
  logic [WORD_AW-1:0]   mem_addr;
  logic [NUM_BANKS-1:0] mem_ce_n;
  logic [NUM_BANKS-1:0] mem_ce;
  logic                 mem_oe_n;
  logic                 mem_we_n;
  logic [DATA_W-1:0]    mem_dq_o;
  logic                 mem_dq_oe;
  logic [DATA_W-1:0]    mem_dq_i = 8'hEE;

  always #2 clk = ~clk;

  asram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [7:0] pm [int];
  logic [7:0] shadow [int];

  bit                q_we [$];
  logic [ADDR_W-1:0] q_addr [$];
  logic [7:0]        q_data [$];
  int                q_gap [$];

  bit                m_act = 1'b0;
  bit                m_we = 1'b0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [7:0]        m_data = '0;
  logic [7:0]        m_rexp = '0;
  int                m_start = 0;
  bit                acc_last = 1'b0;
  int                gap_cnt = 0;
  int                next_gap = 0;
  logic              prev_we_n = 1'b1;

  function automatic logic [7:0] init_byte(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'h3C;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic add(input bit we, input logic [ADDR_W-1:0] a, input logic [7:0] d, input int gap);
    q_we.push_back(we); q_addr.push_back(a); q_data.push_back(d); q_gap.push_back(gap);
  endtask

  function automatic logic [ADDR_W-1:0] pin_addr();
    logic [ADDR_W-1:0] r;
    r = {1'b0, mem_addr};
    if (mem_ce[1]) r[ADDR_W-1] = 1'b1;
    return r;
  endfunction

  task automatic step();
    int d;
    bit busy, rd_win, rd_rsp, w_set, w_pul, w_rec, sel;
    logic [NUM_BANKS-1:0] exp_ce;
    string ph;
    @(negedge clk);
    // behavioural memory: commit on the rising write enable
    if (prev_we_n == 1'b0 && mem_we_n == 1'b1 && mem_ce != '0)
      pm[int'(pin_addr())] = mem_dq_o;
    prev_we_n = mem_we_n;

    d      = cyc - m_start;
    busy   = m_act && (m_we ? (d <= WP_CYC + 2) : (d <= RD_CYC + TA_CYC));
    rd_win = m_act && !m_we && d >= 1 && d <= RD_CYC;
    rd_rsp = m_act && !m_we && d == RD_CYC + 1;
    w_set  = m_act && m_we && d == 1;
    w_pul  = m_act && m_we && d >= 2 && d <= WP_CYC + 1;
    w_rec  = m_act && m_we && d == WP_CYC + 2;
    sel    = rd_win || w_set || w_pul || w_rec;
    exp_ce = sel ? (NUM_BANKS'(1) << m_addr[ADDR_W-1]) : '0;
    if (rd_win) ph = "R3";
    else if (busy && !m_we) ph = "R5";
    else if (busy) ph = "R6";
    else ph = "R9";

    check(req_ready == !busy, "R2", "req_ready", req_ready, !busy);
    check(mem_oe_n == !rd_win, ph, "mem_oe_n", mem_oe_n, !rd_win);
    check(mem_we_n == !w_pul, ph, "mem_we_n", mem_we_n, !w_pul);
    check(mem_dq_oe == w_pul, "R7", "mem_dq_oe", mem_dq_oe, w_pul);
    check(mem_ce == exp_ce, "R8", "mem_ce", mem_ce, exp_ce);
    check(mem_ce_n == ~exp_ce, "R8", "mem_ce_n", mem_ce_n, ~exp_ce);
    check(rsp_valid == rd_rsp, "R4", "rsp_valid", rsp_valid, rd_rsp);
    if (sel) check(mem_addr == m_addr[WORD_AW-1:0], ph, "mem_addr", mem_addr, m_addr[WORD_AW-1:0]);
    if (w_pul || w_rec) check(mem_dq_o == m_data, "R7", "mem_dq_o", mem_dq_o, m_data);
    if (rd_rsp) check(rsp_rdata == m_rexp, "R4", "rsp_rdata", rsp_rdata, m_rexp);

    // memory drives the bus only when selected, reading, not writing
    if (mem_ce != '0 && !mem_oe_n && mem_we_n)
      mem_dq_i = pm.exists(int'(pin_addr())) ? pm[int'(pin_addr())] : init_byte(pin_addr());
    else
      mem_dq_i = 8'hEE;

    // requester
    if (acc_last) begin
      req_valid = 1'b0;
      acc_last  = 1'b0;
      gap_cnt   = next_gap;
    end
    if (!req_valid && q_we.size() != 0) begin
      if (gap_cnt > 0) gap_cnt--;
      else begin
        req_write = q_we.pop_front();
        req_addr  = q_addr.pop_front();
        req_wdata = q_data.pop_front();
        next_gap  = q_gap.pop_front();
        req_valid = 1'b1;
      end
    end
    if (req_valid && !busy) begin
      m_act = 1'b1; m_we = req_write; m_addr = req_addr; m_data = req_wdata; m_start = cyc;
      if (req_write) shadow[int'(req_addr)] = req_wdata;
      else m_rexp = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : init_byte(req_addr);
      acc_last = 1'b1;
    end
  endtask

  initial begin
    // build the access list
    for (int i = 0; i < 12; i++)
      add(1'b1, {i[0], 17'(i * 7919 + 3)}, 8'(i * 29 + 7), i % 3);
    add(1'b1, {1'b0, 17'h00000}, 8'hA5, 0);
    add(1'b1, {1'b1, 17'h1FFFF}, 8'h5A, 0);
    add(1'b1, {1'b1, 17'h00000}, 8'hC3, 1);
    add(1'b1, {1'b0, 17'h1FFFF}, 8'h3C, 0);
    for (int i = 0; i < 12; i++)
      add(1'b0, {i[0], 17'(i * 7919 + 3)}, 8'h00, (i + 1) % 2);
    add(1'b0, {1'b0, 17'h00000}, 8'h00, 0);
    add(1'b0, {1'b1, 17'h1FFFF}, 8'h00, 0);
    add(1'b0, {1'b1, 17'h00000}, 8'h00, 0);
    add(1'b0, {1'b0, 17'h1FFFF}, 8'h00, 0);
    for (int i = 0; i < 6; i++) begin
      add(1'b1, {i[1], 17'(i * 4099 + 11)}, 8'(8'hF0 ^ i), 0);
      add(1'b0, {i[1], 17'(i * 4099 + 11)}, 8'h00, 0);
      add(1'b0, {!i[1], 17'(i * 613 + 5)}, 8'h00, 0);
      add(1'b1, {!i[1], 17'(i * 613 + 5)}, 8'(i * 51), 2);
      add(1'b0, {!i[1], 17'(i * 613 + 5)}, 8'h00, 0);
    end
    add(1'b0, {1'b1, 17'h0ABCD}, 8'h00, 0);
    add(1'b0, {1'b0, 17'h12345}, 8'h00, 0);

    repeat (4) @(posedge clk);
    // R1: outputs while reset is held
    @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "ready/valid in reset",
          {req_ready, rsp_valid}, 2'b10);
    check(mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "strobes in reset",
          {mem_oe_n, mem_we_n, mem_dq_oe}, 3'b110);
    check(mem_ce == '0 && mem_ce_n == '1, "R1", "enables in reset",
          {mem_ce, mem_ce_n}, 4'b0011);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_ce == '0 && mem_oe_n && mem_we_n,
          "R1", "first cycle after reset", {req_ready, rsp_valid, mem_ce, mem_oe_n, mem_we_n},
          6'b100011);
    m_start = cyc - 100;

    while (q_we.size() != 0 || req_valid) step();
    repeat (12) step();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d (cycles, run did not end)", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule